// File: doc/BRIEF.md
# Permission-Checked Set-Associative Tag Directory

This block keeps the bookkeeping side of a set-associative cache without any data storage. For each way of each set it holds a line tag, a two-bit access permission and a lock-owner context. A controller issues one command per cycle. The commands cover a permission-checked lookup, a tag-only peek, an availability query, allocate, free, victim probe, permission update, and lock set, clear and test.

A tag match is not enough for a hit to grant access. Access follows from the stored permission and the request type. Each set runs true least-recently-used replacement with per-way age counters. A successful checked lookup or an allocate makes the touched way the youngest. The probe reports the line address held in the oldest way.

Results are registered and appear one cycle after the command is accepted. Allocate commands that would duplicate a tag or overflow a set are refused with an error flag and leave all state untouched.

Top module: `tagdir_core`

## Requirements
- R1: The set index is the address field of width log2(NUM_SETS) starting at bit IDX_LO, where NUM_SETS = CACHE_BYTES / WAYS / LINE_BYTES. The tag is every address bit above that field. Bits below IDX_LO are ignored.
- R2: From the first cycle after reset `cmd_ready` is high. A command is accepted on every edge where `cmd_valid` is high, and `rsp_valid` is high for exactly the cycle after each accepted command. Opcodes: 0 lookup, 1 peek, 2 avail, 3 alloc, 4 free, 5 probe, 6 setperm, 7 lock, 8 unlock, 9 locktest.
- R3: Permission codes are 0 absent, 1 invalid, 2 read-only and 3 read-write. Request codes are 0 load, 1 fetch and 2 store. A lookup raises `rsp_grant` when the matching line is read-write, or when it is read-only and the request is a load or a fetch. A store to a read-only line is refused.
- R4: For lookup, free and the lock commands, a way whose permission is absent does not match, so `rsp_hit` is 0. Peek and setperm match any occupied way on tag alone. On a hit, `rsp_way` gives the matching way.
- R5: avail sets `rsp_flag` when the set holds the tag, or when any way is empty or absent.
- R6: A successful alloc takes the lowest-numbered empty-or-absent way, reported in `rsp_way`. The new line gets the tag, permission invalid, no lock owner, and becomes the youngest way.
- R7: alloc sets `rsp_err` and changes nothing when an occupied way already carries the tag (whatever its permission) or when no way is free.
- R8: free empties the checked-matching way. Without a checked match it sets `rsp_err`.
- R9: A checked lookup hit and a successful alloc make that way youngest. Every other way that was younger moves up one age step. After reset, the ages in every set equal the way numbers. probe reports the oldest way in `rsp_way` and its line address (offset bits zero) in `rsp_addr`. It sets `rsp_err` when the set still has a free way or holds the tag.
- R10: The lock context all-ones means unlocked. lock stores `cmd_ctx` and unlock restores all-ones, both on a checked match only; otherwise they set `rsp_err`. locktest sets `rsp_flag` only when the stored context equals `cmd_ctx` and `cmd_ctx` is not all-ones.
- R11: setperm writes `cmd_perm` into the tag-matching way, including an absent one. Without a tag match it sets `rsp_err`.
- R12: After reset every way is empty: every lookup misses and avail reports space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 4 | Opcode (R2) |
| cmd_addr | input | ADDR_W | Byte address of the line |
| cmd_req | input | 2 | Request type for lookup |
| cmd_ctx | input | CTX_W | Requester context for lock commands |
| cmd_perm | input | 2 | Permission written by setperm |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Tag matched (checked or raw per opcode) |
| rsp_grant | output | 1 | Lookup access granted |
| rsp_flag | output | 1 | avail or locktest result |
| rsp_err | output | 1 | Command refused |
| rsp_way | output | log2(WAYS) | Matched, allocated or victim way |
| rsp_addr | output | ADDR_W | Victim line address from probe |

## Verification
The bench goes after the permission and request matrix, where a design that treated a tag match as a hit would grant stores to read-only or invalid lines. It also targets an absent line that still carries its tag: a wrong design would hit on it in a checked lookup, fail to reuse its way, or let a second copy of the tag be allocated. Age ordering is checked against an arithmetic model through long touch sequences, so a victim off by one way shows up as a wrong probe address. Lock tests with the reserved unlocked context, and after re-allocation of a locked line, catch a lock that lingers or matches falsely.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

   typedef enum logic [1:0] {
      PERM_ABSENT  = 2'd0,
      PERM_INVALID = 2'd1,
      PERM_RD      = 2'd2,
      PERM_RDWR    = 2'd3
   } perm_e;

   typedef enum logic [1:0] {
      REQ_LOAD  = 2'd0,
      REQ_FETCH = 2'd1,
      REQ_STORE = 2'd2,
      REQ_RSVD  = 2'd3
   } req_e;

   typedef enum logic [3:0] {
      OP_LOOKUP   = 4'd0,
      OP_PEEK     = 4'd1,
      OP_AVAIL    = 4'd2,
      OP_ALLOC    = 4'd3,
      OP_FREE     = 4'd4,
      OP_PROBE    = 4'd5,
      OP_SETPERM  = 4'd6,
      OP_LOCK     = 4'd7,
      OP_UNLOCK   = 4'd8,
      OP_LOCKTEST = 4'd9
   } op_e;

   // Read-write serves every request; read-only serves loads and fetches.
   function automatic logic perm_grants(input perm_e p, input req_e r);
      return (p == PERM_RDWR) ||
             ((p == PERM_RD) && ((r == REQ_LOAD) || (r == REQ_FETCH)));
   endfunction

endpackage

// File: rtl/tagdir_pick.sv
// Lowest-index priority pick over a request vector.
module tagdir_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("tagdir_pick: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/tagdir_index.sv
// Splits a byte address into set index and tag (R1).
module tagdir_index #(
   parameter int ADDR_W = 16,
   parameter int IDX_LO = 4,
   parameter int SET_W  = 2,
   localparam int TAG_W = ADDR_W - IDX_LO - SET_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SET_W-1:0]  set_idx,
   output logic [TAG_W-1:0]  tag
);

   if (TAG_W < 1) begin : g_bad_tag
      $error("tagdir_index: no tag bits left above the set field");
   end

   logic unused_offset;

   assign set_idx       = addr[IDX_LO +: SET_W];
   assign tag           = addr[ADDR_W-1 : IDX_LO + SET_W];
   assign unused_offset = ^addr[IDX_LO-1:0];

endmodule

// File: rtl/tagdir_lru.sv
// True LRU per set with age counters; age WAYS-1 marks the victim (R9).
module tagdir_lru #(
   parameter int NUM_SETS = 4,
   parameter int WAYS     = 4,
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim_way
);

   localparam logic [WAY_W-1:0] ELDEST = WAY_W'(WAYS - 1);

   if ((WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("tagdir_lru: WAYS must be a power of two");
   end

   logic [WAY_W-1:0]  age_q [NUM_SETS][WAYS];
   logic [WAYS-1:0]   eldest [NUM_SETS];
   logic              victim_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign eldest[s][w] = (age_q[s][w] == ELDEST);
      end

      // R9: ages stay a permutation, so exactly one way is oldest
      p_single_eldest_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(eldest[s]) == 1);
   end

   tagdir_pick #(.N(WAYS)) u_victim (
      .req (eldest[rd_set]),
      .any (victim_any),
      .idx (victim_way)
   );

   logic unused_victim_any;
   assign unused_victim_any = victim_any;

endmodule

// File: rtl/tagdir_core.sv
module tagdir_core
   import tagdir_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CACHE_BYTES = 256,
   parameter int LINE_BYTES  = 16,
   parameter int WAYS        = 4,
   parameter int IDX_LO      = 4,
   parameter int CTX_W       = 4,
   localparam int WAY_W      = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [1:0]        cmd_req,
   input  logic [CTX_W-1:0]  cmd_ctx,
   input  logic [1:0]        cmd_perm,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_grant,
   output logic              rsp_flag,
   output logic              rsp_err,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [ADDR_W-1:0] rsp_addr
);

   localparam int NUM_SETS = CACHE_BYTES / WAYS / LINE_BYTES;
   localparam int SET_W    = $clog2(NUM_SETS);
   localparam int TAG_W    = ADDR_W - IDX_LO - SET_W;
   localparam logic [CTX_W-1:0] UNLOCKED = '1;

   // ---------------- elaboration checks ----------------
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("tagdir_core: set count must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("tagdir_core: WAYS must be a power of two of at least 2");
   end
   if ((1 << IDX_LO) < LINE_BYTES) begin : g_bad_idx
      $error("tagdir_core: IDX_LO falls inside the line offset");
   end
   if (CTX_W < 2) begin : g_bad_ctx
      $error("tagdir_core: CTX_W must leave room beside the unlocked value");
   end

   // ---------------- state ----------------
   logic [NUM_SETS-1:0][WAYS-1:0] vld_q;
   logic [TAG_W-1:0]  tag_q  [NUM_SETS][WAYS];
   perm_e             perm_q [NUM_SETS][WAYS];
   logic [CTX_W-1:0]  lock_q [NUM_SETS][WAYS];
   logic              rdy_q;

   // ---------------- decode ----------------
   op_e               op;
   req_e              req;
   logic              fire;
   logic [SET_W-1:0]  set_idx;
   logic [TAG_W-1:0]  tag_in;

   assign op        = op_e'(cmd_op);
   assign req       = req_e'(cmd_req);
   assign cmd_ready = rdy_q;
   assign fire      = cmd_valid && rdy_q;

   tagdir_index #(.ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .SET_W(SET_W)) u_index (
      .addr    (cmd_addr),
      .set_idx (set_idx),
      .tag     (tag_in)
   );

   // ---------------- per-way compare ----------------
   logic [WAYS-1:0] raw_vec, chk_vec, free_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign raw_vec[w]  = vld_q[set_idx][w] && (tag_q[set_idx][w] == tag_in);
      assign chk_vec[w]  = raw_vec[w] && (perm_q[set_idx][w] != PERM_ABSENT);
      assign free_vec[w] = !vld_q[set_idx][w] || (perm_q[set_idx][w] == PERM_ABSENT);
   end

   logic             raw_any, chk_any, free_any;
   logic [WAY_W-1:0] raw_way, chk_way, free_way, victim_way;

   tagdir_pick #(.N(WAYS)) u_pick_raw  (.req(raw_vec),  .any(raw_any),  .idx(raw_way));
   tagdir_pick #(.N(WAYS)) u_pick_chk  (.req(chk_vec),  .any(chk_any),  .idx(chk_way));
   tagdir_pick #(.N(WAYS)) u_pick_free (.req(free_vec), .any(free_any), .idx(free_way));

   logic avail, alloc_ok, touch_en;
   logic [WAY_W-1:0] touch_way;

   assign avail     = raw_any || free_any;
   assign alloc_ok  = !raw_any && free_any;
   assign touch_en  = fire && (((op == OP_LOOKUP) && chk_any) ||
                               ((op == OP_ALLOC) && alloc_ok));
   assign touch_way = (op == OP_ALLOC) ? free_way : chk_way;

   tagdir_lru #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_set     (set_idx),
      .touch_en   (touch_en),
      .touch_set  (set_idx),
      .touch_way  (touch_way),
      .victim_way (victim_way)
   );

   // ---------------- response next values ----------------
   logic              n_hit, n_grant, n_flag, n_err;
   logic [WAY_W-1:0]  n_way;
   logic [ADDR_W-1:0] n_addr;

   always_comb begin
      n_hit   = chk_any;
      n_way   = chk_way;
      n_grant = 1'b0;
      n_flag  = 1'b0;
      n_err   = 1'b0;
      n_addr  = '0;
      case (op)
         OP_LOOKUP:   n_grant = chk_any && perm_grants(perm_q[set_idx][chk_way], req);
         OP_PEEK: begin
            n_hit = raw_any;
            n_way = raw_way;
         end
         OP_AVAIL:    n_flag = avail;
         OP_ALLOC: begin
            n_way = free_way;
            n_err = !alloc_ok;
         end
         OP_FREE, OP_LOCK, OP_UNLOCK: n_err = !chk_any;
         OP_LOCKTEST: begin
            n_err  = !chk_any;
            n_flag = chk_any && (lock_q[set_idx][chk_way] == cmd_ctx) &&
                     (cmd_ctx != UNLOCKED);
         end
         OP_PROBE: begin
            n_way  = victim_way;
            n_err  = avail;
            n_addr = {tag_q[set_idx][victim_way], set_idx, {IDX_LO{1'b0}}};
         end
         OP_SETPERM: begin
            n_hit = raw_any;
            n_way = raw_way;
            n_err = !raw_any;
         end
         default: n_hit = 1'b0;
      endcase
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_flag  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_way   <= '0;
         rsp_addr  <= '0;
         vld_q     <= '0;
         for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]  <= '0;
               perm_q[s][w] <= PERM_ABSENT;
               lock_q[s][w] <= UNLOCKED;
            end
      end else begin
         rdy_q     <= 1'b1;
         rsp_valid <= fire;
         if (fire) begin
            rsp_hit   <= n_hit;
            rsp_grant <= n_grant;
            rsp_flag  <= n_flag;
            rsp_err   <= n_err;
            rsp_way   <= n_way;
            rsp_addr  <= n_addr;
            case (op)
               OP_ALLOC: if (alloc_ok) begin
                  vld_q[set_idx][free_way]  <= 1'b1;
                  tag_q[set_idx][free_way]  <= tag_in;
                  perm_q[set_idx][free_way] <= PERM_INVALID;
                  lock_q[set_idx][free_way] <= UNLOCKED;
               end
               OP_FREE: if (chk_any) begin
                  vld_q[set_idx][chk_way]  <= 1'b0;
                  perm_q[set_idx][chk_way] <= PERM_ABSENT;
                  lock_q[set_idx][chk_way] <= UNLOCKED;
               end
               OP_SETPERM: if (raw_any) perm_q[set_idx][raw_way] <= perm_e'(cmd_perm);
               OP_LOCK:    if (chk_any) lock_q[set_idx][chk_way] <= cmd_ctx;
               OP_UNLOCK:  if (chk_any) lock_q[set_idx][chk_way] <= UNLOCKED;
               default: ;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);

   p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid);

   p_store_ro_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_LOOKUP) && (req == REQ_STORE) && chk_any &&
       (perm_q[set_idx][chk_way] == PERM_RD)) |=> !rsp_grant);

   p_alloc_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_ALLOC) && alloc_ok) |=>
      (vld_q[$past(set_idx)][$past(free_way)] &&
       (perm_q[$past(set_idx)][$past(free_way)] == PERM_INVALID)));

   p_alloc_refused_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_ALLOC) && !alloc_ok) |=> ($stable(vld_q) && rsp_err));

   p_free_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_FREE) && chk_any) |=>
      !vld_q[$past(set_idx)][$past(chk_way)]);

endmodule

// File: tb/sim_tagdir_core.sv
`timescale 1ns/1ps
module sim_tagdir_core;

   localparam int OP_LOOKUP = 0, OP_PEEK = 1, OP_AVAIL = 2, OP_ALLOC = 3,
                  OP_FREE = 4, OP_PROBE = 5, OP_SETPERM = 6, OP_LOCK = 7,
                  OP_UNLOCK = 8, OP_LOCKTEST = 9;
   localparam int NS = 4, NW = 4, UNLK = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [3:0]  cmd_op = '0;
   logic [15:0] cmd_addr = '0;
   logic [1:0]  cmd_req = '0;
   logic [3:0]  cmd_ctx = '0;
   logic [1:0]  cmd_perm = '0;
   logic        rsp_valid, rsp_hit, rsp_grant, rsp_flag, rsp_err;
   logic [1:0]  rsp_way;
   logic [15:0] rsp_addr;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   bit m_vld  [NS][NW];
   int m_tag  [NS][NW];
   int m_perm [NS][NW];
   int m_lock [NS][NW];
   int m_age  [NS][NW];

   always #2.5 clk = ~clk;

   tagdir_core #(.ADDR_W(16), .CACHE_BYTES(256), .LINE_BYTES(16), .WAYS(4),
                 .IDX_LO(4), .CTX_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_ctx(cmd_ctx),
      .cmd_perm(cmd_perm), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_grant(rsp_grant), .rsp_flag(rsp_flag), .rsp_err(rsp_err),
      .rsp_way(rsp_way), .rsp_addr(rsp_addr));

   task automatic chk(input string rq, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic int mk(input int tag, input int set, input int low);
      return (tag << 6) | (set << 4) | (low & 15);
   endfunction

   task automatic touch(input int s, input int w);
      int a = m_age[s][w];
      for (int j = 0; j < NW; j++)
         if (j == w) m_age[s][j] = 0;
         else if (m_age[s][j] < a) m_age[s][j] = m_age[s][j] + 1;
   endtask

   // Drives one command at a negedge, checks its response one cycle later.
   task automatic cmd(input int op, input int addr, input int req, input int ctx, input int perm);
      int s, t, raw_w, chk_w, free_w, vic;
      bit raw_a, chk_a, free_a, avail;
      int e_hit, e_grant, e_flag, e_err, e_way, e_addr;
      bit way_ok, addr_ok;
      string rq;
      s = (addr >> 4) & 3;
      t = (addr >> 6) & 1023;
      raw_a = 0; chk_a = 0; free_a = 0; raw_w = 0; chk_w = 0; free_w = 0; vic = 0;
      for (int w = NW - 1; w >= 0; w--) begin
         if (m_vld[s][w] && m_tag[s][w] == t) begin
            raw_a = 1; raw_w = w;
            if (m_perm[s][w] != 0) begin chk_a = 1; chk_w = w; end
         end
         if (!m_vld[s][w] || m_perm[s][w] == 0) begin free_a = 1; free_w = w; end
         if (m_age[s][w] == NW - 1) vic = w;
      end
      avail = raw_a || free_a;
      e_hit = chk_a; e_grant = 0; e_flag = 0; e_err = 0; e_way = chk_w; e_addr = 0;
      way_ok = chk_a; addr_ok = 0;
      case (op)
         OP_LOOKUP: begin
            rq = "R3";
            e_grant = chk_a && (m_perm[s][chk_w] == 3 ||
                      (m_perm[s][chk_w] == 2 && (req == 0 || req == 1)));
         end
         OP_PEEK:  begin rq = "R4"; e_hit = raw_a; e_way = raw_w; way_ok = raw_a; end
         OP_AVAIL: begin rq = "R5"; e_flag = avail; end
         OP_ALLOC: begin
            e_err = !(!raw_a && free_a);
            rq = e_err ? "R7" : "R6";
            e_way = free_w; way_ok = !e_err;
         end
         OP_FREE:  begin rq = "R8"; e_err = !chk_a; end
         OP_PROBE: begin
            rq = "R9"; e_err = avail; e_way = vic; way_ok = !avail; addr_ok = !avail;
            e_addr = (m_tag[s][vic] << 6) | (s << 4);
         end
         OP_SETPERM: begin rq = "R11"; e_hit = raw_a; e_way = raw_w; way_ok = raw_a; e_err = !raw_a; end
         OP_LOCK, OP_UNLOCK: begin rq = "R10"; e_err = !chk_a; end
         default: begin
            rq = "R10"; e_err = !chk_a;
            e_flag = chk_a && m_lock[s][chk_w] == ctx && ctx != UNLK;
         end
      endcase
      cmd_valid = 1'b1;
      cmd_op    = 4'(op);
      cmd_addr  = 16'(addr);
      cmd_req   = 2'(req);
      cmd_ctx   = 4'(ctx);
      cmd_perm  = 2'(perm);
      // model update
      case (op)
         OP_LOOKUP: if (chk_a) touch(s, chk_w);
         OP_ALLOC: if (!e_err) begin
            m_vld[s][free_w] = 1; m_tag[s][free_w] = t; m_perm[s][free_w] = 1;
            m_lock[s][free_w] = UNLK; touch(s, free_w);
         end
         OP_FREE: if (chk_a) begin m_vld[s][chk_w] = 0; m_perm[s][chk_w] = 0; m_lock[s][chk_w] = UNLK; end
         OP_SETPERM: if (raw_a) m_perm[s][raw_w] = perm;
         OP_LOCK:   if (chk_a) m_lock[s][chk_w] = ctx;
         OP_UNLOCK: if (chk_a) m_lock[s][chk_w] = UNLK;
         default: ;
      endcase
      @(negedge clk);
      chk("R2", "rsp_valid", int'(rsp_valid), 1);
      chk((op == OP_LOOKUP) ? "R4" : rq, "rsp_hit", int'(rsp_hit), e_hit);
      chk(rq, "rsp_grant", int'(rsp_grant), e_grant);
      chk(rq, "rsp_flag", int'(rsp_flag), e_flag);
      chk(rq, "rsp_err", int'(rsp_err), e_err);
      if (way_ok) chk(rq, "rsp_way", int'(rsp_way), e_way);
      if (addr_ok) chk("R1", "rsp_addr", int'(rsp_addr), e_addr);
      cmd_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            m_vld[s][w] = 0; m_tag[s][w] = 0; m_perm[s][w] = 0;
            m_lock[s][w] = UNLK; m_age[s][w] = w;
         end
      repeat (3) @(negedge clk);
      chk("R12", "rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "cmd_ready", int'(cmd_ready), 1);

      // R12: empty after reset; probe on a set with space is refused (R9)
      for (int s = 0; s < NS; s++) begin
         cmd(OP_LOOKUP, mk(3, s, 0), 0, 0, 0);
         cmd(OP_AVAIL, mk(3, s, 0), 0, 0, 0);
         cmd(OP_PROBE, mk(3, s, 0), 0, 0, 0);
      end
      @(negedge clk);
      chk("R2", "idle rsp_valid", int'(rsp_valid), 0);

      // R6: fill every set, lowest way first; offset bits vary (R1)
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++)
            cmd(OP_ALLOC, mk(10 + w + 8 * s, s, w * 5), 0, 0, 0);
      // R7: full set and duplicate tag refused; R5 full set reports no space
      cmd(OP_AVAIL, mk(99, 0, 0), 0, 0, 0);
      cmd(OP_ALLOC, mk(99, 0, 0), 0, 0, 0);
      cmd(OP_ALLOC, mk(12, 0, 0), 0, 0, 0);
      cmd(OP_AVAIL, mk(12, 0, 0), 0, 0, 0);

      // R3/R4: exhaustive permission x request on way 1 of set 0
      for (int p = 0; p < 4; p++) begin
         cmd(OP_SETPERM, mk(11, 0, 0), 0, 0, p);
         for (int q = 0; q < 3; q++) cmd(OP_LOOKUP, mk(11, 0, 3), q, 0, 0);
         cmd(OP_PEEK, mk(11, 0, 0), 0, 0, 0);
      end
      cmd(OP_SETPERM, mk(77, 0, 0), 0, 0, 3);

      // R9: touch sequences then probe victim
      for (int s = 0; s < NS; s++) begin
         cmd(OP_PROBE, mk(50, s, 0), 0, 0, 0);
         for (int k = 0; k < 6; k++) begin
            cmd(OP_LOOKUP, mk(10 + ((k * 3 + s) % 4) + 8 * s, s, 0), 2, 0, 0);
            cmd(OP_PROBE, mk(50, s, 0), 0, 0, 0);
         end
      end

      // R8: free then reuse the lowest free way
      cmd(OP_FREE, mk(27, 2, 0), 0, 0, 0);
      cmd(OP_LOOKUP, mk(27, 2, 0), 0, 0, 0);
      cmd(OP_FREE, mk(27, 2, 0), 0, 0, 0);
      cmd(OP_AVAIL, mk(60, 2, 0), 0, 0, 0);
      cmd(OP_ALLOC, mk(60, 2, 0), 0, 0, 0);

      // R5/R7/R11: absent line keeps its tag, blocks a second copy, frees its way
      cmd(OP_SETPERM, mk(34, 3, 0), 0, 0, 0);
      cmd(OP_LOOKUP, mk(34, 3, 0), 0, 0, 0);
      cmd(OP_PEEK, mk(34, 3, 0), 0, 0, 0);
      cmd(OP_AVAIL, mk(61, 3, 0), 0, 0, 0);
      cmd(OP_ALLOC, mk(34, 3, 0), 0, 0, 0);
      cmd(OP_ALLOC, mk(61, 3, 0), 0, 0, 0);
      cmd(OP_PEEK, mk(34, 3, 0), 0, 0, 0);

      // R10: lock owner
      cmd(OP_LOCK, mk(13, 0, 0), 0, 5, 0);
      cmd(OP_LOCKTEST, mk(13, 0, 0), 0, 5, 0);
      cmd(OP_LOCKTEST, mk(13, 0, 0), 0, 6, 0);
      cmd(OP_LOCKTEST, mk(12, 0, 0), 0, UNLK, 0);
      cmd(OP_UNLOCK, mk(13, 0, 0), 0, 0, 0);
      cmd(OP_LOCKTEST, mk(13, 0, 0), 0, 5, 0);
      cmd(OP_LOCK, mk(88, 0, 0), 0, 5, 0);
      cmd(OP_LOCK, mk(60, 2, 0), 0, 9, 0);
      cmd(OP_FREE, mk(60, 2, 0), 0, 0, 0);
      cmd(OP_ALLOC, mk(62, 2, 0), 0, 0, 0);
      cmd(OP_LOCKTEST, mk(62, 2, 0), 0, 9, 0);

      // Pseudo-random sweep over a small tag space, all opcodes
      r = 32'h1234_5677;
      for (int k = 0; k < 600; k++) begin
         r = r * 32'd1103515245 + 32'd12345;
         cmd(int'((r >> 4) % 10), mk(int'((r >> 8) % 6), int'((r >> 12) % 4), int'((r >> 16) % 16)),
             int'((r >> 20) % 3), int'((r >> 22) % 5) == 4 ? UNLK : int'((r >> 22) % 4),
             int'((r >> 26) % 4));
      end

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule